// File: doc/BRIEF.md
# Falling-Edge DMA Request Acceptor

This block sits between an active-low external request line and one single-address DMA channel. It turns each falling edge seen on the line into exactly one transfer cycle. The line is sampled on every rising clock edge. A low level seen while the block is armed is stored as a pending request. That request is then activated, which clears it, and the bus is requested. Once the grant is seen, one single-address cycle runs with the acknowledge output driven low. The bus is released for one cycle after the cycle ends.

After each activation, the block stops looking for low levels and waits until the line is seen high. It re-arms only when both of these hold: a high level has been sampled, and the current single cycle has ended. A line held low therefore yields one transfer and no more.

A start strobe loads the transfer count and enables the channel. The channel disables itself when the count runs out, and it pulses `done` when that happens. A stop strobe disables the channel at the next quiet point, and it never cuts a transfer that is already in flight. Addresses, data and register access belong to other blocks. No pin carries streamed data, so every port is a plain control or status signal.

Top module: `dma_edge_accept`

## Requirements
- R1: A pin level sampled on the same rising edge that captures `start_stb` is ignored. Sampling takes effect from the next rising edge onward.
- R2: While armed and enabled, one low sample on `dreq_n` latches a request. The request is kept even if the pin returns high on the next edge, and it produces one transfer.
- R3: With `bus_gnt` held high and the sequencer idle, `ack_n` goes low exactly CLEAR_CYC (default 3) cycles after the edge that latched the request.
- R4: After an activation, no new request is accepted until `dreq_n` has been sampled high and the single cycle has ended. A pin held low gives exactly one transfer.
- R5: `bus_req` rises once a request is activated. `ack_n` goes low on the edge after `bus_gnt` is first sampled high, and it stays high while the grant is withheld.
- R6: `ack_n` stays low from the start of the single cycle up to and including the edge that samples `cycle_done` high. In the cycle that follows, both `ack_n` and `bus_req` are inactive (`ack_n` = 1, `bus_req` = 0) for the bus release.
- R7: The count drops by one for each completed single cycle. When the last cycle ends, `done` is high for exactly one cycle and the channel disables itself. `busy` is low from the next cycle on, and later request edges cause no transfer.
- R8: A `start_stb` with `xfer_count` equal to 0 is ignored, and `busy` stays low.
- R9: A `stop_stb` that arrives while a request is active lets that transfer finish. The channel then goes idle without a `done` pulse and accepts no further edges.
- R10: Synchronous reset leaves the block disabled, with no pending request, `ack_n` = 1 and `bus_req`, `busy` and `done` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edges |
| rst | input | 1 | Synchronous reset, active high |
| start_stb | input | 1 | One-cycle strobe: load count and enable channel |
| stop_stb | input | 1 | One-cycle strobe: disable after current transfer |
| xfer_count | input | CNT_W | Number of transfers loaded on `start_stb` |
| dreq_n | input | 1 | Active-low external DMA request line |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| cycle_done | input | 1 | High when the single-address bus cycle completes |
| bus_req | output | 1 | Bus request to the arbiter |
| ack_n | output | 1 | Active-low transfer acknowledge |
| busy | output | 1 | Channel enabled or a transfer still in progress |
| done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The bench drives the request line at falling clock edges and notes the cycle number at which it did so. If the line goes low in cycle c, the acknowledge must fall in cycle c+4: one edge to latch the request and CLEAR_CYC further edges up to the start of the transfer. When the grant is delayed instead, the acknowledge is due one cycle after the grant rises. The `done` pulse is due one cycle after the acknowledge ends.

The driver puts each of these cycle numbers into a scoreboard queue. The monitor samples at the falling edge and compares every acknowledge start and every `done` pulse against the head of that queue. Any event for which no entry was queued is reported as a failure. The monitor also measures each acknowledge pulse against the response delay applied to `cycle_done`, and it checks that the bus is released in the cycle after.

// File: rtl/dma_edge_pkg.sv
package dma_edge_pkg;

  // acceptance side: where the request line watcher stands
  typedef enum logic [1:0] {
    ACC_ARM       = 2'd0,  // looking for a low level
    ACC_SEEK_HI   = 2'd1,  // activated, transfer running, high not yet seen
    ACC_HI_OK     = 2'd2,  // high seen, waiting for the transfer to end
    ACC_SEEK_POST = 2'd3   // transfer ended, line still low
  } acc_st_e;

  // transfer sequencer
  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_HOLD = 3'd1,  // clearance gap before asking for the bus
    SEQ_REQ  = 3'd2,  // bus requested, waiting for grant
    SEQ_XFER = 3'd3,  // single-address cycle, acknowledge active
    SEQ_REL  = 3'd4   // bus released for one cycle
  } seq_st_e;

endpackage

// File: rtl/dma_req_accept.sv
module dma_req_accept
  import dma_edge_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dreq_n,
  input  logic act,
  input  logic xfer_end,
  output logic pend,
  output logic armed
);

  acc_st_e st_q, st_d;
  logic    pend_d;

  always_comb begin
    st_d   = st_q;
    pend_d = pend;
    unique case (st_q)
      ACC_ARM: begin
        if (act) begin
          pend_d = 1'b0;
          st_d   = ACC_SEEK_HI;
        end else if (!dreq_n) begin
          pend_d = 1'b1;
        end
      end
      ACC_SEEK_HI: begin
        if (dreq_n) st_d = xfer_end ? ACC_ARM : ACC_HI_OK;
        else if (xfer_end) st_d = ACC_SEEK_POST;
      end
      ACC_HI_OK: begin
        if (xfer_end) st_d = ACC_ARM;
      end
      ACC_SEEK_POST: begin
        if (dreq_n) st_d = ACC_ARM;
      end
      default: st_d = ACC_ARM;
    endcase
    // a disabled channel forgets everything and samples nothing
    if (!en) begin
      st_d   = ACC_ARM;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ACC_ARM;
      pend <= 1'b0;
    end else begin
      st_q <= st_d;
      pend <= pend_d;
    end
  end

  assign armed = (st_q == ACC_ARM);

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_edge_pkg::*;
#(
  parameter int HOLD_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pend,
  input  logic armed,
  input  logic bus_gnt,
  input  logic cycle_done,
  output logic act,
  output logic xfer_end,
  output logic bus_req,
  output logic ack_n,
  output logic idle
);

  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  seq_st_e         st_q, st_d;
  logic [HW-1:0]   hold_q;

  assign act      = (st_q == SEQ_IDLE) && pend && armed && en;
  assign xfer_end = (st_q == SEQ_XFER) && cycle_done;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (act) st_d = SEQ_HOLD;
      SEQ_HOLD: if (hold_q == HOLD_LAST) st_d = SEQ_REQ;
      SEQ_REQ:  if (bus_gnt) st_d = SEQ_XFER;
      SEQ_XFER: if (cycle_done) st_d = SEQ_REL;
      SEQ_REL:  st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == SEQ_HOLD) hold_q <= hold_q + 1'b1;
      else                  hold_q <= '0;
    end
  end

  assign bus_req = (st_q == SEQ_REQ) || (st_q == SEQ_XFER);
  assign ack_n   = (st_q != SEQ_XFER);
  assign idle    = (st_q == SEQ_IDLE);

endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_stb,
  input  logic             stop_stb,
  input  logic [CNT_W-1:0] count_in,
  input  logic             xfer_end,
  input  logic             quiet,
  input  logic             idle,
  output logic             en,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;
  logic             stop_q;
  logic             stop_any;

  assign stop_any = stop_q || stop_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      done     <= 1'b0;
      stop_q   <= 1'b0;
      remain_q <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        stop_q <= 1'b0;
        if (start_stb && idle && (count_in != '0)) begin
          en       <= 1'b1;
          remain_q <= count_in;
        end
      end else begin
        if (stop_stb) stop_q <= 1'b1;
        if (xfer_end) begin
          remain_q <= remain_q - ONE;
          if (remain_q == ONE) begin
            en     <= 1'b0;
            done   <= 1'b1;
            stop_q <= 1'b0;
          end else if (stop_any) begin
            en     <= 1'b0;
            stop_q <= 1'b0;
          end
        end else if (stop_any && quiet) begin
          en     <= 1'b0;
          stop_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dma_edge_accept.sv
module dma_edge_accept #(
  parameter int CNT_W     = 16,
  parameter int CLEAR_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_stb,
  input  logic             stop_stb,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             dreq_n,
  input  logic             bus_gnt,
  input  logic             cycle_done,
  output logic             bus_req,
  output logic             ack_n,
  output logic             busy,
  output logic             done
);

  // latch edge -> activation edge -> hold cycles -> request -> transfer
  localparam int HOLD_CYC = (CLEAR_CYC > 3) ? (CLEAR_CYC - 2) : 1;

  logic en_w, pend_w, armed_w, act_w, xend_w, idle_w, quiet_w;

  assign quiet_w = idle_w && !pend_w;
  assign busy    = en_w || !idle_w;

  dma_req_accept u_accept (
    .clk      (clk),
    .rst      (rst),
    .en       (en_w),
    .dreq_n   (dreq_n),
    .act      (act_w),
    .xfer_end (xend_w),
    .pend     (pend_w),
    .armed    (armed_w)
  );

  dma_xfer_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (en_w),
    .pend       (pend_w),
    .armed      (armed_w),
    .bus_gnt    (bus_gnt),
    .cycle_done (cycle_done),
    .act        (act_w),
    .xfer_end   (xend_w),
    .bus_req    (bus_req),
    .ack_n      (ack_n),
    .idle       (idle_w)
  );

  dma_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start_stb (start_stb),
    .stop_stb  (stop_stb),
    .count_in  (xfer_count),
    .xfer_end  (xend_w),
    .quiet     (quiet_w),
    .idle      (idle_w),
    .en        (en_w),
    .done      (done)
  );

endmodule

// File: rtl/dma_edge_accept_chk.sv
module dma_edge_accept_chk #(
  parameter int CLEAR_CYC = 3
) (
  input logic clk,
  input logic rst,
  input logic bus_gnt,
  input logic bus_req,
  input logic ack_n,
  input logic busy,
  input logic done,
  input logic pend
);

  logic       pend_q;
  logic [7:0] gap_q;

  // cycles since the pending request was latched, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      pend_q <= pend;
      if (pend && !pend_q)   gap_q <= 8'd1;
      else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
    end
  end

  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ack_n && !bus_req && !busy && !done));

  // R5
  grant_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> ($past(bus_req) && $past(bus_gnt)));

  // R3
  clearance_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> (gap_q >= 8'(CLEAR_CYC)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_n) |-> !bus_req);

  // R7
  done_once_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

endmodule

bind dma_edge_accept dma_edge_accept_chk #(.CLEAR_CYC(CLEAR_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_gnt (bus_gnt),
  .bus_req (bus_req),
  .ack_n   (ack_n),
  .busy    (busy),
  .done    (done),
  .pend    (pend_w)
);

// File: tb/dma_edge_accept_tb.sv
`timescale 1ns/1ps
module dma_edge_accept_tb;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_stb = 1'b0;
  logic          stop_stb = 1'b0;
  logic [CW-1:0] xfer_count = '0;
  logic          dreq_n = 1'b1;
  logic          bus_gnt = 1'b1;
  logic          cycle_done = 1'b0;
  logic          bus_req, ack_n, busy, done;

  dma_edge_accept #(.CNT_W(CW), .CLEAR_CYC(3)) u_dut (
    .clk(clk), .rst(rst), .start_stb(start_stb), .stop_stb(stop_stb),
    .xfer_count(xfer_count), .dreq_n(dreq_n), .bus_gnt(bus_gnt),
    .cycle_done(cycle_done), .bus_req(bus_req), .ack_n(ack_n),
    .busy(busy), .done(done)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef enum int {EV_ACK, EV_DONE} ev_e;
  typedef struct { ev_e kind; int cyc; } ev_t;
  ev_t sbq[$];

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int wait_cfg = 0;
  int acks_seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  // bus slave model: completes the cycle after wait_cfg extra cycles
  initial begin
    int w = 0;
    forever begin
      @(negedge clk);
      if (!ack_n) begin
        if (w >= wait_cfg) cycle_done = 1'b1;
        else w++;
      end else begin
        cycle_done = 1'b0;
        w = 0;
      end
    end
  end

  // monitor: pops the scoreboard on each acknowledge start and done pulse
  initial begin
    logic prev = 1'b1;
    int   low_len = 0;
    ev_t  e;
    forever begin
      @(negedge clk);
      if (prev && !ack_n) begin
        acks_seen++;
        if (sbq.size() == 0) check(1'b0, "R4", "unexpected ack start at cycle", cyc, -1);
        else begin
          e = sbq.pop_front();
          check(e.kind == EV_ACK && e.cyc == cyc, "R3", "ack start cycle", cyc, e.cyc);
        end
      end
      if (!ack_n) low_len++;
      if (!prev && ack_n) begin
        check(low_len == wait_cfg + 1, "R6", "ack low width", low_len, wait_cfg + 1);
        check(!bus_req, "R6", "bus_req in release cycle", int'(bus_req), 0);
        low_len = 0;
      end
      if (done) begin
        if (sbq.size() == 0) check(1'b0, "R7", "unexpected done at cycle", cyc, -1);
        else begin
          e = sbq.pop_front();
          check(e.kind == EV_DONE && e.cyc == cyc, "R7", "done cycle", cyc, e.cyc);
        end
      end
      prev = ack_n;
    end
  end

  // driver: one low stretch on the request line, expectations queued
  task automatic pulse(input int low_cyc, input bit exp_ack, input bit exp_done);
    int c;
    @(negedge clk);
    c = cyc;
    dreq_n = 1'b0;
    if (exp_ack)  sbq.push_back('{EV_ACK, c + 4});
    if (exp_done) sbq.push_back('{EV_DONE, c + 4 + wait_cfg + 1});
    repeat (low_cyc) @(negedge clk);
    dreq_n = 1'b1;
  endtask

  task automatic start(input int cnt);
    @(negedge clk);
    xfer_count = CW'(cnt);
    start_stb  = 1'b1;
    @(negedge clk);
    start_stb  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic grant_now(input bit exp_done);
    int g;
    @(negedge clk);
    g = cyc;
    bus_gnt = 1'b1;
    sbq.push_back('{EV_ACK, g + 1});
    if (exp_done) sbq.push_back('{EV_DONE, g + 1 + wait_cfg + 1});
  endtask

  initial begin
    int a0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(ack_n == 1'b1, "R10", "ack_n after reset", int'(ack_n), 1);
    check(!bus_req, "R10", "bus_req after reset", int'(bus_req), 0);
    check(!busy && !done, "R10", "busy/done after reset", int'(busy), 0);

    // R1: low only on the edge that captures the start strobe
    @(negedge clk);
    xfer_count = CW'(4);
    start_stb  = 1'b1;
    dreq_n     = 1'b0;
    @(negedge clk);
    start_stb  = 1'b0;
    dreq_n     = 1'b1;
    idle(10);
    check(acks_seen == 0, "R1", "acks after pre-enable low", acks_seen, 0);
    check(busy == 1'b1, "R1", "channel enabled", int'(busy), 1);

    // R2: a single low sample is held and served
    a0 = acks_seen;
    pulse(1, 1'b1, 1'b0);
    idle(10);
    check(acks_seen == a0 + 1, "R2", "acks for one-cycle pulse", acks_seen, a0 + 1);

    // R4: held low gives one transfer only
    a0 = acks_seen;
    pulse(20, 1'b1, 1'b0);
    idle(8);
    check(acks_seen == a0 + 1, "R4", "acks for held-low pin", acks_seen, a0 + 1);

    // R6: slow slave, acknowledge held for three cycles
    wait_cfg = 2;
    a0 = acks_seen;
    pulse(1, 1'b1, 1'b0);
    idle(12);
    check(acks_seen == a0 + 1, "R6", "acks with slow slave", acks_seen, a0 + 1);
    wait_cfg = 0;

    // R5: grant withheld, last transfer of the count
    bus_gnt = 1'b0;
    pulse(1, 1'b0, 1'b0);
    idle(4);
    check(bus_req == 1'b1, "R5", "bus_req while waiting for grant", int'(bus_req), 1);
    check(ack_n == 1'b1, "R5", "ack_n while waiting for grant", int'(ack_n), 1);
    grant_now(1'b1);
    idle(8);
    check(!busy, "R7", "busy after count exhausted", int'(busy), 0);

    // R7: edges after done are ignored
    a0 = acks_seen;
    pulse(1, 1'b0, 1'b0);
    idle(10);
    check(acks_seen == a0 && !bus_req, "R7", "acks after done", acks_seen, a0);

    // R8: zero count does not enable
    start(0);
    idle(3);
    check(!busy, "R8", "busy after zero-count start", int'(busy), 0);

    // R9: stop while a transfer waits for the bus
    start(3);
    bus_gnt = 1'b0;
    pulse(1, 1'b0, 1'b0);
    idle(3);
    @(negedge clk);
    stop_stb = 1'b1;
    @(negedge clk);
    stop_stb = 1'b0;
    check(busy == 1'b1, "R9", "busy with transfer in flight", int'(busy), 1);
    grant_now(1'b0);
    idle(8);
    check(!busy, "R9", "busy after stop completes", int'(busy), 0);
    a0 = acks_seen;
    pulse(1, 1'b0, 1'b0);
    idle(10);
    check(acks_seen == a0, "R9", "acks after stop", acks_seen, a0);

    check(sbq.size() == 0, "R3", "expected events left over", sbq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule